// File: doc/BRIEF.md
# Scan-Gap Sample Decimator

This block is a streaming filter placed between a converter that produces samples at a fixed convert rate and a consumer that needs scans at a slower, whole-multiple period. The samples arrive as groups of back-to-back scans of N channels. The block treats each run of N × (1 + D) samples as one chunk. It forwards the first N samples of each chunk and discards the other D scans. In this way a fixed convert clock can emulate a scan period that is (1 + D) scan times long.

A start pulse loads the channel count N, the gap D, a scan count and a run-forever flag. In count mode the block loads a budget of scans × N × (1 + D) samples. Every accepted sample uses one unit of this budget, whether the sample is kept or dropped. When the budget runs out, the block pulses a done flag and stops accepting input until the next start. In run-forever mode it keeps filtering with no end. The output is registered. The consumer must accept every output sample, because the block has no back-pressure.

Top module: `scan_gap_decimator`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid_o`, `done_o` and `active_o` are 0.
- R2: A cycle with `start_i` high latches N, D, the scan count and the mode. If run-forever is set or the scan count is non-zero, `active_o` is 1 from the next cycle. With a scan count of 0 in count mode, `active_o` stays 0.
- R3: A sample is accepted when `in_valid_i` is high, `active_o` is high and `start_i` is low. If the chunk position of an accepted sample is below N, the block puts the same data on `out_data_o` with `out_valid_o` high in the following cycle.
- R4: An accepted sample at chunk position N or above produces no output.
- R5: The chunk position starts at 0 on start and advances by one per accepted sample. It wraps to 0 after position N × (1 + D) − 1, so the keep/drop pattern repeats for every chunk.
- R6: With D = 0, every accepted sample is forwarded.
- R7: In count mode, exactly scans × N × (1 + D) samples are accepted, counting both kept and dropped ones. `done_o` is high for exactly one cycle: the cycle after the final sample is accepted. From that same cycle, `active_o` is 0.
- R8: While `active_o` is 0, input samples have no effect: there is no output and no done pulse.
- R9: In run-forever mode, `done_o` never rises and `active_o` stays 1.
- R10: A start during an acquisition discards the current chunk position and budget and reloads both from the configuration inputs.
- R11: Cycles with `in_valid_i` low advance neither the chunk position nor the budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load configuration and begin acquisition |
| cfg_nchan_i | input | 5 | Channels per scan N, 1..16 |
| cfg_gap_i | input | 16 | Dropped scans per chunk D |
| cfg_scans_i | input | 16 | Scans to acquire in count mode |
| cfg_forever_i | input | 1 | 1 selects run-forever mode |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | 16 | Input sample |
| out_valid_o | output | 1 | Forwarded sample valid |
| out_data_o | output | 16 | Forwarded sample |
| done_o | output | 1 | One-cycle end-of-acquisition pulse |
| active_o | output | 1 | Block is accepting samples |

## Verification
The assertions assume three things about the inputs. N is between 1 and 16 whenever start is pulsed. The consumer takes every output sample. Start is a single-cycle pulse. The assertions also rely on the latched mode that the checker tracks from start, which lets the done properties hold in both modes. The stimulus pulses start for one cycle only, and always with legal N. It changes configuration inputs only around a start. It never holds the output back. Because of this, the count-mode and run-forever properties are both exercised, including the restart during a run and the zero-scan start.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  typedef enum logic {
    MODE_COUNT   = 1'b0,
    MODE_FOREVER = 1'b1
  } run_mode_e;

  function automatic int unsigned chan_bits(input int unsigned max_chan);
    return $clog2(max_chan + 1);
  endfunction
endpackage

// File: rtl/sgd_chunk_track.sv
module sgd_chunk_track #(
  parameter int unsigned CHAN_W = 5,
  parameter int unsigned CNT_W  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CHAN_W-1:0] nchan_i,
  input  logic [CNT_W-1:0]  chunk_len_i,
  input  logic              step_i,
  output logic              keep_o
);
  logic [CHAN_W-1:0] nchan_q;
  logic [CNT_W-1:0]  last_q;
  logic [CNT_W-1:0]  pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nchan_q <= '0;
      last_q  <= '0;
      pos_q   <= '0;
    end else if (load_i) begin
      nchan_q <= nchan_i;
      last_q  <= chunk_len_i - CNT_W'(1);
      pos_q   <= '0;
    end else if (step_i) begin
      pos_q <= (pos_q == last_q) ? '0 : pos_q + CNT_W'(1);
    end
  end

  assign keep_o = (pos_q < CNT_W'(nchan_q));
endmodule

// File: rtl/sgd_budget.sv
module sgd_budget #(
  parameter int unsigned SCAN_W = 16,
  parameter int unsigned CNT_W  = 22,
  localparam int unsigned BUD_W = SCAN_W + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SCAN_W-1:0] scans_i,
  input  logic [CNT_W-1:0]  chunk_len_i,
  input  sgd_pkg::run_mode_e mode_i,
  input  logic              step_i,
  output logic              active_o,
  output logic              last_o
);
  import sgd_pkg::*;

  logic [BUD_W-1:0] budget_q;
  run_mode_e        mode_q;
  logic             active_q;
  logic             final_unit;

  assign final_unit = (budget_q == BUD_W'(1));
  assign last_o     = step_i && (mode_q == MODE_COUNT) && final_unit;
  assign active_o   = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      budget_q <= '0;
      mode_q   <= MODE_COUNT;
      active_q <= 1'b0;
    end else if (load_i) begin
      budget_q <= BUD_W'(scans_i) * BUD_W'(chunk_len_i);
      mode_q   <= mode_i;
      active_q <= (mode_i == MODE_FOREVER) || (scans_i != '0);
    end else if (step_i && mode_q == MODE_COUNT) begin
      budget_q <= budget_q - BUD_W'(1);
      if (final_unit) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_gap_decimator.sv
module scan_gap_decimator #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MAX_CHAN = 16,
  parameter int unsigned GAP_W    = 16,
  parameter int unsigned SCAN_W   = 16,
  localparam int unsigned CHAN_W  = sgd_pkg::chan_bits(MAX_CHAN),
  localparam int unsigned CNT_W   = CHAN_W + GAP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CHAN_W-1:0] cfg_nchan_i,
  input  logic [GAP_W-1:0]  cfg_gap_i,
  input  logic [SCAN_W-1:0] cfg_scans_i,
  input  logic              cfg_forever_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              done_o,
  output logic              active_o
);
  import sgd_pkg::*;

  logic [CNT_W-1:0]  chunk_len;
  logic              accept;
  logic              keep;
  logic              last;
  logic              running;
  logic              out_valid_q;
  logic [DATA_W-1:0] out_data_q;
  logic              done_q;
  run_mode_e         mode;

  assign chunk_len = CNT_W'(cfg_nchan_i) * (CNT_W'(cfg_gap_i) + CNT_W'(1));
  assign mode      = cfg_forever_i ? MODE_FOREVER : MODE_COUNT;
  assign accept    = in_valid_i && running && !start_i;

  sgd_chunk_track #(.CHAN_W(CHAN_W), .CNT_W(CNT_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_i),
    .nchan_i     (cfg_nchan_i),
    .chunk_len_i (chunk_len),
    .step_i      (accept),
    .keep_o      (keep)
  );

  sgd_budget #(.SCAN_W(SCAN_W), .CNT_W(CNT_W)) u_budget (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_i),
    .scans_i     (cfg_scans_i),
    .chunk_len_i (chunk_len),
    .mode_i      (mode),
    .step_i      (accept),
    .active_o    (running),
    .last_o      (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      done_q      <= 1'b0;
    end else begin
      out_valid_q <= accept && keep;
      if (accept && keep) out_data_q <= in_data_i;
      done_q      <= last;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign done_o      = done_q;
  assign active_o    = running;
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker #(
  parameter int unsigned SCAN_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [SCAN_W-1:0] cfg_scans_i,
  input logic              cfg_forever_i,
  input logic              in_valid_i,
  input logic              out_valid_o,
  input logic              done_o,
  input logic              active_o
);
  logic forever_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) forever_q <= 1'b0;
    else if (start_i) forever_q <= cfg_forever_i;
  end

  a_r3_out_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i && active_o && !start_i));

  a_r8_idle_no_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |=> !out_valid_o);

  a_r7_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_o);

  a_r9_forever_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    forever_q |-> !done_o);

  a_r2_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (cfg_forever_i || cfg_scans_i != '0)) |=> active_o);
endmodule

bind scan_gap_decimator sgd_checker #(.SCAN_W(SCAN_W)) u_chk (.*);

// File: tb/tb_scan_gap_decimator.sv
module tb_scan_gap_decimator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  nchan = 5'd1;
  logic [15:0] gap = '0;
  logic [15:0] scans = '0;
  logic        fv = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        done;
  logic        active;

  int checks = 0;
  int fails = 0;
  bit ended = 0;
  int seed = 1;

  logic [15:0] exp_q[$];
  int     m_n, m_len, m_pos;
  longint m_budget;
  bit     m_fv, m_active;

  always #10 clk = ~clk;

  scan_gap_decimator dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_nchan_i(nchan),
    .cfg_gap_i(gap), .cfg_scans_i(scans), .cfg_forever_i(fv),
    .in_valid_i(in_valid), .in_data_i(in_data), .out_valid_o(out_valid),
    .out_data_o(out_data), .done_o(done), .active_o(active)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: every forwarded sample must match the head of the scoreboard (R3/R4/R5/R6)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) chk(0, "R4/R8 unexpected output", out_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(out_data === e, "R3/R5 forwarded data", out_data, e);
        end
      end
    end
  end

  task automatic do_start(input int n, input int d, input int sc, input bit f);
    nchan = 5'(n); gap = 16'(d); scans = 16'(sc); fv = f; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    m_n = n; m_len = n * (d + 1); m_pos = 0; m_fv = f;
    m_budget = longint'(sc) * m_len;
    m_active = f || (sc != 0);
    chk(active === m_active, "R2 active after start", active, m_active);
    chk(done === 1'b0, "R2 no done on start", done, 0);
  endtask

  task automatic feed(input int cnt, input int gap_every, input string tag);
    for (int i = 0; i < cnt; i++) begin
      logic [15:0] d;
      bit exp_done;
      d = 16'(seed * 37 + 11);
      seed++;
      exp_done = 0;
      in_valid = 1'b1;
      in_data = d;
      if (m_active) begin
        if (m_pos < m_n) exp_q.push_back(d);
        m_pos = (m_pos + 1 == m_len) ? 0 : m_pos + 1;
        if (!m_fv) begin
          m_budget--;
          if (m_budget == 0) begin m_active = 0; exp_done = 1; end
        end
      end
      @(posedge clk); #2;
      in_valid = 1'b0;
      chk(done === exp_done, {tag, " R7 done timing"}, done, exp_done);
      chk(active === m_active, {tag, " R7/R9 active"}, active, m_active);
      if (gap_every != 0 && (i % gap_every) == 0) begin
        @(posedge clk); #2;
        chk(done === 1'b0, {tag, " R11 idle cycle"}, done, 0);
      end
    end
    repeat (2) @(posedge clk);
    #2;
    chk(exp_q.size() == 0, {tag, " R3 all outputs seen"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(done === 1'b0, "R1 reset done", done, 0);
    chk(active === 1'b0, "R1 reset active", active, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(active === 1'b0, "R1 after release", active, 0);

    // R4 R5: N=3, D=2, two scans -> 18 samples, 6 kept
    do_start(3, 2, 2, 0);
    feed(18, 0, "R4");
    // R8: inputs after end ignored
    feed(6, 0, "R8");

    // R6: no gap, all pass
    do_start(4, 0, 3, 0);
    feed(12, 3, "R6");

    // R9 R11: run forever with idle cycles
    do_start(1, 3, 0, 1);
    feed(41, 2, "R9");

    // R10: restart mid-run reloads position and budget
    do_start(2, 1, 5, 0);
    feed(5, 0, "R10a");
    do_start(16, 0, 1, 0);
    feed(20, 0, "R10");

    // R5: widest scan with gap
    do_start(16, 1, 1, 0);
    feed(32, 7, "R5");

    // R2: zero scans in count mode stays idle
    do_start(2, 0, 0, 0);
    feed(4, 0, "R2");

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule